// File: doc/BRIEF.md
# PWM Controller Register and Interrupt Interface

This block is the register front end of a multi-channel pulse-width modulation controller. A simple synchronous bus reaches it through an address, a write strobe, a read strobe, write data and read data. It holds the global mode word and the channel-enable bits. It also holds the interrupt mask and the pending-interrupt bits. For each channel it decodes a register window that holds mode, duty, period, counter and update registers.

The waveform generators sit outside the block. They consume the configuration outputs and return two things: a live counter value per channel and a one-cycle end-of-period pulse per channel.

The enable bits and the mask bits cannot be written directly. Each has one address that sets bits and another that clears bits. A pending bit is raised by its channel's period-end pulse and is cleared when software reads the pending register. The block raises a single interrupt line whenever any channel is both pending and unmasked.

Top module: `pwm_regif`

## Requirements
- R1: After a synchronous reset every readable register reads 0 and `irq` is 0.
- R2: Writing to 0x04 sets each channel-enable bit whose data bit is 1. Writing to 0x08 clears each such bit. Data bits that are 0 leave the enable bit unchanged. The enable bits read back at 0x0C (bit n = channel n) and drive `chan_en`.
- R3: Writing to 0x10 sets interrupt-mask bits and writing to 0x14 clears them, with the same rule for 0 bits as R2. The mask reads back at 0x18 (bit n = channel n).
- R4: A 1 on `eop[n]` sets pending bit n in the register at 0x1C on the next clock edge, whatever the mask holds.
- R5: A read of 0x1C returns the pending bits and clears them. A period-end pulse that arrives in the same cycle as that read stays pending afterwards.
- R6: `irq` is 1 exactly when some channel is both pending and unmasked. It stays 1 until the read of 0x1C clears the pending bits.
- R7: The global mode register at 0x00 is read/write, resets to 0, and drives `glob_mode`.
- R8: Channel n's registers lie at 0x200 + n*0x20. The mode (+0x00), duty (+0x04) and period (+0x08) registers are read/write and drive the `chan_mode`, `chan_duty` and `chan_period` slices for that channel.
- R9: Channel counter reads at +0x0C return the `chan_count` slice for that channel. Writes to that offset have no effect.
- R10: A write to channel n's update offset (+0x10) sets `upd_val` slice n to the write data. In the cycle after the write, `upd_stb[n]` is 1 for exactly one cycle. A read of that offset returns 0.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` and is 0 otherwise. Reads of write-only, reserved, misaligned or out-of-range-channel addresses return 0. Writes to read-only or reserved addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| eop | input | NCH | Per-channel end-of-period pulses |
| chan_count | input | NCH*32 | Live counter value of each channel |
| irq | output | 1 | Combined interrupt |
| glob_mode | output | 32 | Global mode register |
| chan_en | output | NCH | Channel enable bits |
| chan_mode | output | NCH*32 | Per-channel mode registers |
| chan_duty | output | NCH*32 | Per-channel duty registers |
| chan_period | output | NCH*32 | Per-channel period registers |
| upd_val | output | NCH*32 | Per-channel last update value |
| upd_stb | output | NCH | One-cycle pulse after an update write |

## Verification
The set and clear registers are tested with three kinds of write: data that sets new bits, all-zero data, and data that clears one bit. Together these show a true set/clear pair apart from a plain store or a toggle.

Period-end pulses are tested in three situations: on a masked channel, on an unmasked channel, and in the same cycle as a pending-register read. These separate the pending bit from the interrupt gating, and show that the clear does not swallow an event arriving with the read.

Address patterns cover several cases: channel windows at different indices, the first address past the last channel, reserved space, and writes to read-only locations. Together these expose stride and range errors in the decoder.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
    localparam int DW         = 32;
    localparam int AW         = 12;
    localparam int GLOB_SPAN  = 32;
    localparam int CH_BASE    = 'h200;
    localparam int CH_STRIDE  = 'h20;
    localparam int CH_SHIFT   = $clog2(CH_STRIDE);
    localparam int CH_FIELDS  = 5;

    typedef enum logic [2:0] {
        G_MODE, G_ENSET, G_ENCLR, G_ENSTAT, G_MSET, G_MCLR, G_MASK, G_PEND
    } glob_e;

    localparam logic [2:0] F_MODE = 3'd0;
    localparam logic [2:0] F_DUTY = 3'd1;
    localparam logic [2:0] F_PER  = 3'd2;
    localparam logic [2:0] F_CNT  = 3'd3;
    localparam logic [2:0] F_UPD  = 3'd4;

    typedef struct packed {
        logic       hit_glob;
        glob_e      gsel;
        logic       hit_ch;
        logic [7:0] ch;
        logic [2:0] fld;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a, input int nch);
        dec_t d;
        logic [AW-1:0] off;
        d   = '0;
        off = a - AW'(CH_BASE);
        if (a[1:0] == 2'b00) begin
            if (a < AW'(GLOB_SPAN)) begin
                d.hit_glob = 1'b1;
                d.gsel     = glob_e'(a[4:2]);
            end else if (a >= AW'(CH_BASE)) begin
                d.ch     = 8'(off >> CH_SHIFT);
                d.fld    = off[CH_SHIFT-1:2];
                d.hit_ch = (int'(d.ch) < nch) && (int'(d.fld) < CH_FIELDS);
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/pwmr_setclr.sv
module pwmr_setclr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (set_stb) q <= q | bits;
        else if (clr_stb) q <= q & ~bits;
    end

    // R2 / R3: set strobe raises every selected bit
    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> ((q & $past(bits)) == $past(bits)));
    // R2 / R3: clear strobe drops every selected bit
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !set_stb) |=> ((q & $past(bits)) == '0));
    // R2 / R3: unselected bits keep their value
    p_keep_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (set_stb || clr_stb) |=> ((q & ~$past(bits)) == ($past(q) & ~$past(bits))));
endmodule

// File: rtl/pwmr_pend.sv
module pwmr_pend #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] eop,
    input  logic         rd_clr,
    output logic [W-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (rd_clr ? '0 : pend) | eop;
    end

    // R4: a period-end pulse is always captured
    p_eop_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (eop != '0) |=> ((pend & $past(eop)) == $past(eop)));
    // R5: after a clearing read only same-cycle events remain
    p_rd_clear_r5: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (pend == $past(eop)));
endmodule

// File: rtl/pwmr_chan.sv
module pwmr_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [2:0]    fld,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode,
    output logic [DW-1:0] duty,
    output logic [DW-1:0] period,
    output logic [DW-1:0] upd,
    output logic          upd_stb
);
    import pwmr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            duty    <= '0;
            period  <= '0;
            upd     <= '0;
            upd_stb <= 1'b0;
        end else begin
            upd_stb <= wr && (fld == F_UPD);
            if (wr) begin
                case (fld)
                    F_MODE:  mode   <= wdata;
                    F_DUTY:  duty   <= wdata;
                    F_PER:   period <= wdata;
                    F_UPD:   upd    <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // R10: strobe follows an update write by one cycle
    p_upd_follows_r10: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> ($past(wr) && $past(fld) == F_UPD));
endmodule

// File: rtl/pwm_regif.sv
module pwm_regif #(
    parameter int NCH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [pwmr_pkg::AW-1:0]   bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [pwmr_pkg::DW-1:0]   bus_wdata,
    output logic [pwmr_pkg::DW-1:0]   bus_rdata,
    input  logic [NCH-1:0]            eop,
    input  logic [NCH*pwmr_pkg::DW-1:0] chan_count,
    output logic                      irq,
    output logic [pwmr_pkg::DW-1:0]   glob_mode,
    output logic [NCH-1:0]            chan_en,
    output logic [NCH*pwmr_pkg::DW-1:0] chan_mode,
    output logic [NCH*pwmr_pkg::DW-1:0] chan_duty,
    output logic [NCH*pwmr_pkg::DW-1:0] chan_period,
    output logic [NCH*pwmr_pkg::DW-1:0] upd_val,
    output logic [NCH-1:0]            upd_stb
);
    import pwmr_pkg::*;

    dec_t           d;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] pend_q;
    logic [DW-1:0]  rval;
    logic           wr_g;

    assign d    = decode(bus_addr, NCH);
    assign wr_g = bus_wr && d.hit_glob;

    always_ff @(posedge clk) begin
        if (rst)                       glob_mode <= '0;
        else if (wr_g && d.gsel == G_MODE) glob_mode <= bus_wdata;
    end

    pwmr_setclr #(.W(NCH)) u_en (
        .clk(clk), .rst(rst),
        .set_stb(wr_g && d.gsel == G_ENSET),
        .clr_stb(wr_g && d.gsel == G_ENCLR),
        .bits(bus_wdata[NCH-1:0]), .q(chan_en));

    pwmr_setclr #(.W(NCH)) u_mask (
        .clk(clk), .rst(rst),
        .set_stb(wr_g && d.gsel == G_MSET),
        .clr_stb(wr_g && d.gsel == G_MCLR),
        .bits(bus_wdata[NCH-1:0]), .q(mask_q));

    pwmr_pend #(.W(NCH)) u_pend (
        .clk(clk), .rst(rst), .eop(eop),
        .rd_clr(bus_rd && d.hit_glob && d.gsel == G_PEND),
        .pend(pend_q));

    assign irq = |(pend_q & mask_q);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwmr_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst(rst),
            .wr(bus_wr && d.hit_ch && d.ch == 8'(i)),
            .fld(d.fld), .wdata(bus_wdata),
            .mode(chan_mode[i*DW +: DW]),
            .duty(chan_duty[i*DW +: DW]),
            .period(chan_period[i*DW +: DW]),
            .upd(upd_val[i*DW +: DW]),
            .upd_stb(upd_stb[i]));
    end

    always_comb begin
        rval = '0;
        if (d.hit_glob) begin
            case (d.gsel)
                G_MODE:   rval = glob_mode;
                G_ENSTAT: rval = DW'(chan_en);
                G_MASK:   rval = DW'(mask_q);
                G_PEND:   rval = DW'(pend_q);
                default:  rval = '0;
            endcase
        end else if (d.hit_ch) begin
            for (int i = 0; i < NCH; i++) begin
                if (d.ch == 8'(i)) begin
                    case (d.fld)
                        F_MODE:  rval = chan_mode[i*DW +: DW];
                        F_DUTY:  rval = chan_duty[i*DW +: DW];
                        F_PER:   rval = chan_period[i*DW +: DW];
                        F_CNT:   rval = chan_count[i*DW +: DW];
                        default: rval = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rval;
        else             bus_rdata <= '0;
    end

    // R6: no unmasked channel, no interrupt
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);
    // R11: read data is zero when no read was issued
    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> (bus_rdata == '0));
    // R10: at most one update strobe per cycle
    p_upd_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_stb));
endmodule

// File: tb/tb_pwm_regif.sv
module tb_pwm_regif;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int NV  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [11:0]       bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NCH-1:0]    eop = '0;
    logic [NCH*DW-1:0] chan_count = '0;
    logic              irq;
    logic [DW-1:0]     glob_mode;
    logic [NCH-1:0]    chan_en;
    logic [NCH*DW-1:0] chan_mode, chan_duty, chan_period, upd_val;
    logic [NCH-1:0]    upd_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pwm_regif #(.NCH(NCH)) dut (.*);

    always #10 clk = ~clk;

    // {is_read, addr, data, expected}
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'hA5A5_0003, 32'h0},
        {1'b1, 12'h000, 32'h0, 32'hA5A5_0003},
        {1'b0, 12'h004, 32'h5, 32'h0},
        {1'b1, 12'h00C, 32'h0, 32'h5},
        {1'b0, 12'h004, 32'h0, 32'h0},
        {1'b1, 12'h00C, 32'h0, 32'h5},
        {1'b0, 12'h008, 32'h4, 32'h0},
        {1'b1, 12'h00C, 32'h0, 32'h1},
        {1'b0, 12'h010, 32'hA, 32'h0},
        {1'b1, 12'h018, 32'h0, 32'hA},
        {1'b0, 12'h014, 32'h2, 32'h0},
        {1'b1, 12'h018, 32'h0, 32'h8},
        {1'b0, 12'h00C, 32'hF, 32'h0},
        {1'b1, 12'h00C, 32'h0, 32'h1},
        {1'b1, 12'h004, 32'h0, 32'h0},
        {1'b0, 12'h244, 32'h1234, 32'h0},
        {1'b1, 12'h244, 32'h0, 32'h1234},
        {1'b0, 12'h268, 32'hFFFF, 32'h0},
        {1'b1, 12'h268, 32'h0, 32'hFFFF},
        {1'b0, 12'h280, 32'hDEAD, 32'h0},
        {1'b1, 12'h280, 32'h0, 32'h0},
        {1'b1, 12'h100, 32'h0, 32'h0},
        {1'b0, 12'h01C, 32'hF, 32'h0},
        {1'b1, 12'h01C, 32'h0, 32'h0}
    };

    function automatic string vtag(input int i);
        case (i)
            1:           return "R7";
            3, 5, 7:     return "R2";
            9, 11:       return "R3";
            16, 18:      return "R8";
            default:     return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] e);
        @(negedge clk);
        eop = e;
        @(negedge clk);
        eop = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", DW'(irq), 0);
        rd(12'h000, v); check("R1 mode", v, 0);
        rd(12'h00C, v); check("R1 enable", v, 0);
        rd(12'h018, v); check("R1 mask", v, 0);
        rd(12'h01C, v); check("R1 pending", v, 0);
        rd(12'h260, v); check("R1 chan mode", v, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) begin
                rd(VEC[i][75:64], v);
                check(vtag(i), v, VEC[i][31:0]);
            end else begin
                wr(VEC[i][75:64], VEC[i][63:32]);
            end
        end

        check("R7 glob_mode port", glob_mode, 32'hA5A5_0003);
        check("R2 chan_en port", DW'(chan_en), 1);
        check("R8 chan_duty port", chan_duty[2*DW +: DW], 32'h1234);
        check("R8 chan_period port", chan_period[3*DW +: DW], 32'hFFFF);

        // mask now 4'b1000
        pulse(4'b0001);
        check("R6 masked no irq", DW'(irq), 0);
        rd(12'h01C, v); check("R4 pending masked", v, 1);
        rd(12'h01C, v); check("R5 cleared", v, 0);
        pulse(4'b1000);
        check("R6 irq high", DW'(irq), 1);
        @(negedge clk);
        check("R6 irq held", DW'(irq), 1);
        rd(12'h01C, v); check("R5 read value", v, 8);
        check("R6 irq dropped", DW'(irq), 0);

        // event in the same cycle as the clearing read
        pulse(4'b0001);
        @(negedge clk);
        bus_addr = 12'h01C; bus_rd = 1'b1; eop = 4'b1000;
        @(negedge clk);
        bus_rd = 1'b0; eop = '0;
        check("R5 old value", bus_rdata, 1);
        check("R6 new event irq", DW'(irq), 1);
        rd(12'h01C, v); check("R5 kept event", v, 8);

        // counter
        chan_count[1*DW +: DW] = 32'h77;
        rd(12'h22C, v); check("R9 counter", v, 32'h77);
        wr(12'h22C, 32'h1);
        rd(12'h22C, v); check("R9 write ignored", v, 32'h77);

        // update strobe
        @(negedge clk);
        bus_addr = 12'h230; bus_wdata = 32'hBEEF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 strobe", DW'(upd_stb), 32'b0010);
        check("R10 value", upd_val[1*DW +: DW], 32'hBEEF);
        @(negedge clk);
        check("R10 strobe one cycle", DW'(upd_stb), 0);
        rd(12'h230, v); check("R10 read zero", v, 0);
        rd(12'h01E, v); check("R11 misaligned", v, 0);
        check("R11 idle rdata", bus_rdata, 0);
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule